// File: doc/BRIEF.md
# Boundary Register Chain for Device Pins

This block forms the boundary-register segment of a test access port for a set of device pins. Every pin is declared by a parameter bit as either bidirectional or input-only. A bidirectional pin gets three scan cells: one for its output enable, one for its output data and one that samples the pad. Each of the two drive cells has a shift/capture flop followed by an update register. An input-only pin gets one cell that samples the pad. That cell has no update stage and never drives the pad.

An external TAP controller supplies the data-register strobes (shift, capture/shift clock enable, update) and the instruction decodes: external test, high-impedance and programming mode. Outside test, core data and enables reach the pads. An active-low test output enable can float every pin. During external test or programming, the pads take their data and enable from the update registers, so the core logic is cut off from them. The serial output is taken from the last cell and re-timed on the falling test-clock edge.

All strobes are synchronous enables sampled on the rising edge of `tck`. No clock is gated.

Top module: `bsc_pin_chain`

## Requirements
- R1: With external test and programming mode both low, `toe_n` high and `highz` low, each bidirectional pin's `pad_out` equals its `core_out` and its `pad_oe` equals its `core_oe` (1 = drive).
- R2: When `clock_dr` and `shift_dr` are both high at a rising `tck`, the chain shifts by one cell. `scan_in` enters the first cell. For each pin in index order starting at pin 0, a bidirectional pin contributes its cells as enable, data, pad sample, and an input-only pin contributes one pad-sample cell. The last cell feeds `scan_out`.
- R3: While `extest` is high, each bidirectional pin's `pad_out` and `pad_oe` come from its update registers, and changes on `core_out` and `core_oe` have no effect on the pads.
- R4: While `highz` is high, every `pad_oe` bit is 0 in every mode.
- R5: With `toe_n` low, every `pad_oe` bit is 0 in normal mode. During external test, `toe_n` has no effect on the pads.
- R6: An input-only pin always has `pad_out` and `pad_oe` at 0.
- R7: The update registers load from their shift cells only on a rising `tck` with `update_dr` high. Shifting without an update leaves the pads unchanged.
- R8: `trst_n` low asynchronously clears all shift cells, all update registers and `scan_out`.
- R9: When `clock_dr` is high and `shift_dr` is low at a rising `tck`, every cell captures its source. The enable cell captures `core_oe`, the data cell captures `core_out`, and the pad-sample cells capture `pad_in`.
- R10: `scan_out` takes the last cell's value at each falling `tck` edge.
- R11: While `prog_mode` is high, the pads are driven from the update registers exactly as under external test.
- R12: With `clock_dr` low, no shift cell changes, whatever `shift_dr` and `scan_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| shift_dr | input | 1 | Selects shift (1) or capture (0) |
| clock_dr | input | 1 | Enables the shift/capture flops |
| update_dr | input | 1 | Loads the update registers |
| extest | input | 1 | External test: pads driven from update registers |
| highz | input | 1 | Forces all output enables off |
| prog_mode | input | 1 | Programming mode: isolates the core from the pads |
| toe_n | input | 1 | Active-low test output enable, used in normal mode |
| scan_in | input | 1 | Serial data into the first cell |
| core_out | input | NUM_PINS | Core output data per pin |
| core_oe | input | NUM_PINS | Core output enable per pin |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data driven toward each pad |
| pad_oe | output | NUM_PINS | Output enable toward each pad |
| scan_out | output | 1 | Serial data from the last cell, falling-edge timed |

## Verification
The bench builds the chain with three pins: a bidirectional pin, an input-only pin and a second bidirectional pin (`PIN_KIND = 3'b101`, seven cells). This places an input-only cell between two full pin groups, so a single serial read shows whether the cell order and the per-kind cell count are right. It also shows that the middle pin never drives, even when its core inputs are high. With seven cells, a full shift-in, update and shift-out stays short enough that each mode override gets its own directed scenario.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  localparam int MAX_PINS = 64;

  // number of bidirectional pins among the first n
  function automatic int count_io(input logic [MAX_PINS-1:0] kinds, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++)
      if (kinds[i]) c++;
    return c;
  endfunction

  // index of the first cell belonging to pin p
  function automatic int cell_base(input logic [MAX_PINS-1:0] kinds, input int p);
    int b;
    b = 0;
    for (int i = 0; i < p; i++)
      b += kinds[i] ? 3 : 1;
    return b;
  endfunction

  function automatic int chain_len(input logic [MAX_PINS-1:0] kinds, input int n);
    return cell_base(kinds, n);
  endfunction

  // pad enable resolution: highz wins, then test lock, then toe_n gating
  function automatic logic resolve_oe(input logic hz, input logic lock,
                                      input logic upd_oe, input logic core_oe,
                                      input logic toe_n);
    if (hz)   return 1'b0;
    if (lock) return upd_oe;
    return core_oe & toe_n;
  endfunction

endpackage

// File: rtl/bsc_shift_cell.sv
module bsc_shift_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_dr,
  input  logic clock_dr,
  input  logic scan_prev,
  input  logic cap_val,
  output logic sh_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sh_q <= 1'b0;
    else if (clock_dr) sh_q <= shift_dr ? scan_prev : cap_val;
  end
endmodule

// File: rtl/bsc_io_pin.sv
module bsc_io_pin (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_dr,
  input  logic clock_dr,
  input  logic update_dr,
  input  logic extest,
  input  logic prog_mode,
  input  logic highz,
  input  logic toe_n,
  input  logic scan_prev,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  output logic sh_oe,
  output logic sh_dat,
  output logic sh_inp,
  output logic pad_out,
  output logic pad_oe,
  output logic upd_dat,
  output logic upd_oe
);
  logic lock;

  bsc_shift_cell oe_cell (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .scan_prev(scan_prev), .cap_val(core_oe), .sh_q(sh_oe));

  bsc_shift_cell dat_cell (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .scan_prev(sh_oe), .cap_val(core_out), .sh_q(sh_dat));

  bsc_shift_cell inp_cell (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .scan_prev(sh_dat), .cap_val(pad_in), .sh_q(sh_inp));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_dat <= 1'b0;
      upd_oe  <= 1'b0;
    end else if (update_dr) begin
      upd_dat <= sh_dat;
      upd_oe  <= sh_oe;
    end
  end

  assign lock    = extest | prog_mode;
  assign pad_out = lock ? upd_dat : core_out;
  assign pad_oe  = bsc_pkg::resolve_oe(highz, lock, upd_oe, core_oe, toe_n);
endmodule

// File: rtl/bsc_tdo_stage.sv
module bsc_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic last_cell,
  output logic scan_out
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) scan_out <= 1'b0;
    else         scan_out <= last_cell;
  end
endmodule

// File: rtl/bsc_pin_chain.sv
module bsc_pin_chain #(
  parameter int                  NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] PIN_KIND = 8'b1011_0111
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                shift_dr,
  input  logic                clock_dr,
  input  logic                update_dr,
  input  logic                extest,
  input  logic                highz,
  input  logic                prog_mode,
  input  logic                toe_n,
  input  logic                scan_in,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                scan_out
);
  localparam logic [bsc_pkg::MAX_PINS-1:0] KIND_X = bsc_pkg::MAX_PINS'(PIN_KIND);
  localparam int CHAIN_LEN = bsc_pkg::chain_len(KIND_X, NUM_PINS);

  // serial links: link[k] feeds cell k, link[k+1] is cell k's output
  logic [CHAIN_LEN:0]   link;
  logic [CHAIN_LEN-1:0] chain_w;
  logic [NUM_PINS-1:0]  upd_data_w;
  logic [NUM_PINS-1:0]  upd_oe_w;

  assign link[0] = scan_in;
  assign chain_w = link[CHAIN_LEN:1];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BASE = bsc_pkg::cell_base(KIND_X, p);
    if (PIN_KIND[p]) begin : g_io
      bsc_io_pin pin_i (
        .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
        .update_dr(update_dr), .extest(extest), .prog_mode(prog_mode),
        .highz(highz), .toe_n(toe_n), .scan_prev(link[BASE]),
        .core_out(core_out[p]), .core_oe(core_oe[p]), .pad_in(pad_in[p]),
        .sh_oe(link[BASE+1]), .sh_dat(link[BASE+2]), .sh_inp(link[BASE+3]),
        .pad_out(pad_out[p]), .pad_oe(pad_oe[p]),
        .upd_dat(upd_data_w[p]), .upd_oe(upd_oe_w[p]));
    end else begin : g_in
      logic unused_core;
      assign unused_core = core_out[p] ^ core_oe[p];
      bsc_shift_cell cell_i (
        .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
        .scan_prev(link[BASE]), .cap_val(pad_in[p]), .sh_q(link[BASE+1]));
      assign pad_out[p]    = 1'b0;
      assign pad_oe[p]     = 1'b0;
      assign upd_data_w[p] = 1'b0;
      assign upd_oe_w[p]   = 1'b0;
    end
  end

  bsc_tdo_stage tdo_i (
    .tck(tck), .trst_n(trst_n), .last_cell(link[CHAIN_LEN]), .scan_out(scan_out));

endmodule

// File: rtl/bsc_pin_chain_chk.sv
module bsc_pin_chain_chk #(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] PIN_KIND  = 8'b1011_0111,
  parameter int                  CHAIN_LEN = 20
) (
  input logic                 tck,
  input logic                 trst_n,
  input logic                 clock_dr,
  input logic                 update_dr,
  input logic                 extest,
  input logic                 highz,
  input logic                 prog_mode,
  input logic                 toe_n,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic [NUM_PINS-1:0]  upd_data_w,
  input logic [NUM_PINS-1:0]  upd_oe_w,
  input logic [CHAIN_LEN-1:0] chain_w
);
  a_r4_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
    highz |-> (pad_oe == '0));

  a_r5_toe_tristate: assert property (@(posedge tck) disable iff (!trst_n)
    (!extest && !prog_mode && !toe_n) |-> (pad_oe == '0));

  a_r3_extest_from_latch: assert property (@(posedge tck) disable iff (!trst_n)
    (extest && !highz) |-> ((pad_out & PIN_KIND) == (upd_data_w & PIN_KIND)
                            && (pad_oe & PIN_KIND) == (upd_oe_w & PIN_KIND)));

  a_r7_latch_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable({upd_data_w, upd_oe_w}));

  a_r12_chain_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !clock_dr |=> $stable(chain_w));

  a_r6_input_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    ((pad_oe | pad_out) & ~PIN_KIND) == '0);
endmodule

bind bsc_pin_chain bsc_pin_chain_chk #(
  .NUM_PINS(NUM_PINS), .PIN_KIND(PIN_KIND), .CHAIN_LEN(CHAIN_LEN)
) chk_i (
  .tck(tck), .trst_n(trst_n), .clock_dr(clock_dr), .update_dr(update_dr),
  .extest(extest), .highz(highz), .prog_mode(prog_mode), .toe_n(toe_n),
  .pad_out(pad_out), .pad_oe(pad_oe), .upd_data_w(upd_data_w),
  .upd_oe_w(upd_oe_w), .chain_w(chain_w)
);

// File: tb/bsc_pin_chain_tb_top.sv
`timescale 1ns/1ps
module bsc_pin_chain_tb_top;
  localparam int N = 3;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic shift_dr = 0, clock_dr = 0, update_dr = 0;
  logic extest = 0, highz = 0, prog_mode = 0, toe_n = 1, scan_in = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic scan_out;
  int tests = 0, fails = 0;

  always #2.5 tck = ~tck;

  bsc_pin_chain #(.NUM_PINS(N), .PIN_KIND(3'b101)) dut_i (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .update_dr(update_dr), .extest(extest), .highz(highz),
    .prog_mode(prog_mode), .toe_n(toe_n), .scan_in(scan_in),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .scan_out(scan_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic s, input logic u);
    clock_dr = c; shift_dr = s; update_dr = u;
    @(posedge tck); #1;
    clock_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  // cell k receives v[k]; v[6] goes in first
  task automatic shift_in(input logic [6:0] v);
    for (int i = 6; i >= 0; i--) begin
      scan_in = v[i];
      pulse(1, 1, 0);
    end
    scan_in = 0;
  endtask

  task automatic read_chain(input bit do_cap, output logic [6:0] got);
    if (do_cap) pulse(1, 0, 0);
    @(negedge tck); #1;
    got[6] = scan_out;
    for (int k = 5; k >= 0; k--) begin
      pulse(1, 1, 0);
      @(negedge tck); #1;
      got[k] = scan_out;
    end
  endtask

  task automatic t_reset();
    extest = 1; #1;
    chk("R8 reset pad_out", pad_out, 0);
    chk("R8 reset pad_oe", pad_oe, 0);
    chk("R8 reset scan_out", scan_out, 0);
    extest = 0;
  endtask

  task automatic t_normal();
    core_out = 3'b111; core_oe = 3'b111; toe_n = 1; #1;
    chk("R1 normal pad_out", pad_out, 3'b101);
    chk("R1 normal pad_oe", pad_oe, 3'b101);
    chk("R6 input pin quiet", {pad_out[1], pad_oe[1]}, 0);
    toe_n = 0; #1;
    chk("R5 toe_n floats pins", pad_oe, 0);
    chk("R5 data unaffected", pad_out, 3'b101);
    toe_n = 1;
  endtask

  task automatic t_capture();
    logic [6:0] got;
    pad_in = 3'b011; core_out = 3'b001; core_oe = 3'b100;
    read_chain(1, got);
    chk("R9 R2 R10 capture and order", got,
        {pad_in[2], core_out[2], core_oe[2], pad_in[1], pad_in[0], core_out[0], core_oe[0]});
  endtask

  task automatic t_extest();
    shift_in(7'b0110001);
    pulse(0, 0, 1);
    extest = 1; core_out = 0; core_oe = 0; #1;
    chk("R3 extest pad_out", pad_out, 3'b100);
    chk("R3 extest pad_oe", pad_oe, 3'b101);
    core_out = 3'b111; core_oe = 3'b111; toe_n = 0; #1;
    chk("R3 core ignored pad_out", pad_out, 3'b100);
    chk("R5 toe_n ignored in extest", pad_oe, 3'b101);
    toe_n = 1;
  endtask

  task automatic t_hold();
    shift_in(7'b1001110);
    #1;
    chk("R7 no update pad_out", pad_out, 3'b100);
    chk("R7 no update pad_oe", pad_oe, 3'b101);
  endtask

  task automatic t_highz();
    highz = 1; #1;
    chk("R4 highz in extest", pad_oe, 0);
    chk("R4 data kept", pad_out, 3'b100);
    extest = 0; #1;
    chk("R4 highz in normal", pad_oe, 0);
    highz = 0;
  endtask

  task automatic t_prog();
    prog_mode = 1; core_out = 3'b000; core_oe = 3'b000; #1;
    chk("R11 prog pad_out", pad_out, 3'b100);
    chk("R11 prog pad_oe", pad_oe, 3'b101);
    prog_mode = 0; #1;
    chk("R1 back to core", pad_oe, 3'b000);
  endtask

  task automatic t_noclk();
    logic [6:0] got;
    shift_in(7'b1010011);
    shift_dr = 1; clock_dr = 0; scan_in = 1;
    repeat (3) @(posedge tck);
    #1; shift_dr = 0; scan_in = 0;
    read_chain(0, got);
    chk("R12 chain held without clock_dr", got, 7'b1010011);
  endtask

  task automatic t_async_reset();
    shift_in(7'b0110011);
    pulse(0, 0, 1);
    extest = 1; #1;
    chk("R7 update loaded", pad_oe, 3'b101);
    trst_n = 0; #1;
    chk("R8 async reset pad_oe", pad_oe, 0);
    chk("R8 async reset pad_out", pad_out, 0);
    chk("R8 async reset scan_out", scan_out, 0);
    trst_n = 1; extest = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12 trst_n = 1;
    @(posedge tck); #1;
    t_reset();
    t_normal();
    t_capture();
    t_extest();
    t_hold();
    t_highz();
    t_prog();
    t_noclk();
    @(posedge tck); #1;
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule